// File: doc/BRIEF.md
# AGC Update Sync Hold-Off Controller

This block decides the cycles on which the averaging and decimation stage of an automatic gain control loop hands a new update sample to the loop filter. A receive channel that leaves sleep, a software sync request, or an external sync pulse from a downstream symbol-rate receiver loads a programmable hold-off count. The count runs down once per master clock. When it reaches zero the block strobes an update and then keeps strobing at the configured decimation rate. No update comes out while a hold-off is running, so a sync aligned to a symbol boundary keeps the gain word constant until the next boundary.

The block can also pulse a clear of the decimation accumulator together with the first update after a sync countdown. It can stay armed for any number of syncs, or accept only the first sync after wake-up. Software configures it through a plain write port with three addresses. The filters and the gain path are outside this block.

The state machine has four states. `ST_SLEEP` is the channel asleep. `ST_WAKE_HOLD` is the countdown after wake-up. `ST_SYNC_HOLD` is the countdown after an accepted sync. `ST_DECIM` is free-running decimation. The transitions are:
- wake (`ST_SLEEP` to `ST_WAKE_HOLD` when sleep is low).
- sync (any awake state to `ST_SYNC_HOLD` on an accepted sync).
- expire (a hold state to `ST_DECIM` when the count is zero).
- doze (any awake state to `ST_SLEEP` when sleep is high).

When more than one applies, doze wins over sync, and sync wins over expire.

Top module: `agc_sync_holdoff`

## Requirements
- R1: While reset is applied and right after it, update_strobe and accum_clear are low, armed is high, and the block is asleep; reset values are control 0, hold-off 0, decimation 0.
- R2: If sleep is low in cycle T while the block is asleep, the first update_strobe is high in cycle T+1+H, where H is the hold-off register (address 1). No strobe comes before it.
- R3: After the first strobe of a countdown, update_strobe repeats every D+1 cycles, where D is the decimation register (address 2, low bits).
- R4: Writing the control register (address 0) with bit 3 set in cycle T is a sync request. When the block is awake and armed, it gives the next strobe in cycle T+1+H, and no strobe between.
- R5: An ext_sync pulse in cycle T acts as a sync request only when control bit 0 (external sync enable) is set; otherwise it has no effect on the strobe timing.
- R6: When control bit 2 (init on sync) is set, accum_clear is high together with the first strobe that ends a sync countdown, and on no other cycle. It is never high without update_strobe.
- R7: When control bit 1 (first sync only) is set, an accepted sync drops armed from the next cycle on. While armed is low, every sync request is ignored, until sleep is raised.
- R8: A sync accepted during a countdown or during decimation restarts the count from the full hold-off register value.
- R9: update_strobe is low in every cycle in which sleep is high. Sleep returns the block to the asleep state and sets armed high from the next cycle.
- R10: A hold-off value of 0 gives the strobe in the cycle right after the triggering wake or sync.
- R11: Control bits 0 to 2 take effect from the cycle after their write; a sync-now write uses the previous first-sync-only setting. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Channel sleep request, high holds the block asleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 hold-off, 2 decimation |
| wr_data | input | HOLD_W (16) | Write data |
| ext_sync | input | 1 | Sync pulse from the downstream symbol receiver |
| update_strobe | output | 1 | One-cycle pulse: pass an update to the loop filter |
| accum_clear | output | 1 | One-cycle pulse: clear the decimation accumulator |
| armed | output | 1 | High while further sync requests will be accepted |

## Verification
Every result is due at a cycle that can be counted from its trigger. The first strobe after a wake or sync is due 1+H cycles after the trigger cycle, and later strobes follow every D+1 cycles. An armed change shows one cycle after the accepted sync, and the sleep gating of the strobe acts in the same cycle. The bench records the trigger cycle when it drives each stimulus and queues the exact cycles at which strobes are due. It then compares on the falling edge, so a strobe that comes one cycle early or late, or that should have been suppressed, counts as a mismatch.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP     = 2'd0,
        ST_WAKE_HOLD = 2'd1,
        ST_SYNC_HOLD = 2'd2,
        ST_DECIM     = 2'd3
    } agc_state_e;

    localparam int ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HOLD  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DECIM = 2'd2;

    localparam int BIT_EXT_EN     = 0;
    localparam int BIT_FIRST_ONLY = 1;
    localparam int BIT_INIT_SYNC  = 2;
    localparam int BIT_SYNC_NOW   = 3;

    typedef struct packed {
        logic init_on_sync;
        logic first_only;
        logic ext_en;
    } agc_ctrl_t;

endpackage

// File: rtl/agc_sync_regs.sv
module agc_sync_regs
    import agc_sync_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOLD_W = 16,
    parameter int DEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output agc_ctrl_t         ctrl,
    output logic [HOLD_W-1:0] holdoff,
    output logic [DEC_W-1:0]  decim,
    output logic              sync_now
);

    logic wr_ctrl;
    logic wr_hold;
    logic wr_decim;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_hold  = wr_en && (wr_addr == ADDR_HOLD);
    assign wr_decim = wr_en && (wr_addr == ADDR_DECIM);

    // the sync-now bit is a request, not a stored field
    assign sync_now = wr_ctrl && wr_data[BIT_SYNC_NOW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.ext_en       <= wr_data[BIT_EXT_EN];
            ctrl.first_only   <= wr_data[BIT_FIRST_ONLY];
            ctrl.init_on_sync <= wr_data[BIT_INIT_SYNC];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holdoff <= '0;
        end else if (wr_hold) begin
            holdoff <= wr_data[HOLD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decim <= '0;
        end else if (wr_decim) begin
            decim <= wr_data[DEC_W-1:0];
        end
    end

endmodule

// File: rtl/agc_sync_downcnt.sv
module agc_sync_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] cnt,
    output logic         zero
);

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec_en && !zero) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/agc_sync_fsm.sv
module agc_sync_fsm
    import agc_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic       sync_req,
    input  logic       hold_zero,
    input  logic       dec_zero,
    input  agc_ctrl_t  ctrl,
    output agc_state_e state,
    output logic       sync_acc,
    output logic       hold_load,
    output logic       hold_run,
    output logic       dec_load,
    output logic       dec_run,
    output logic       update_strobe,
    output logic       accum_clear,
    output logic       armed
);

    agc_state_e state_nx;
    logic       in_hold;
    logic       awake;
    logic       expire;
    logic       tick_fire;

    assign in_hold  = (state == ST_WAKE_HOLD) || (state == ST_SYNC_HOLD);
    assign awake    = (state != ST_SLEEP) && !sleep;
    assign sync_acc = sync_req && armed && awake;
    assign expire   = in_hold && hold_zero && awake && !sync_acc;
    assign tick_fire = (state == ST_DECIM) && dec_zero && awake && !sync_acc;

    // next-state selection: doze > sync > expire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP: begin
                if (!sleep) state_nx = ST_WAKE_HOLD;
            end
            ST_WAKE_HOLD, ST_SYNC_HOLD: begin
                if (sleep)          state_nx = ST_SLEEP;
                else if (sync_acc)  state_nx = ST_SYNC_HOLD;
                else if (hold_zero) state_nx = ST_DECIM;
            end
            ST_DECIM: begin
                if (sleep)         state_nx = ST_SLEEP;
                else if (sync_acc) state_nx = ST_SYNC_HOLD;
            end
            default: state_nx = ST_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= state_nx;
    end

    // arming: restored by sleep, dropped by a sync when one-shot is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (sleep || state == ST_SLEEP) begin
            armed <= 1'b1;
        end else if (sync_acc && ctrl.first_only) begin
            armed <= 1'b0;
        end
    end

    // outputs and counter controls
    always_comb begin
        hold_load     = ((state == ST_SLEEP) && !sleep) || sync_acc;
        hold_run      = in_hold;
        dec_load      = expire || tick_fire;
        dec_run       = (state == ST_DECIM);
        update_strobe = expire || tick_fire;
        accum_clear   = expire && (state == ST_SYNC_HOLD) && ctrl.init_on_sync;
    end

endmodule

// File: rtl/agc_sync_holdoff.sv
module agc_sync_holdoff
    import agc_sync_pkg::*;
#(
    parameter int HOLD_W = 16,
    parameter int DEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HOLD_W-1:0] wr_data,
    input  logic              ext_sync,
    output logic              update_strobe,
    output logic              accum_clear,
    output logic              armed
);

    localparam int DATA_W = HOLD_W;

    agc_ctrl_t         ctrl;
    logic [HOLD_W-1:0] holdoff;
    logic [DEC_W-1:0]  decim;
    logic              sync_now;
    logic              sync_req;
    logic              sync_acc;
    agc_state_e        state;
    logic              hold_load;
    logic              hold_run;
    logic              hold_zero;
    logic [HOLD_W-1:0] hold_cnt;
    logic              dec_load;
    logic              dec_run;
    logic              dec_zero;
    logic [DEC_W-1:0]  dec_cnt;

    agc_sync_regs #(
        .DATA_W (DATA_W),
        .HOLD_W (HOLD_W),
        .DEC_W  (DEC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .holdoff  (holdoff),
        .decim    (decim),
        .sync_now (sync_now)
    );

    assign sync_req = sync_now || (ctrl.ext_en && ext_sync);

    agc_sync_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .sync_req      (sync_req),
        .hold_zero     (hold_zero),
        .dec_zero      (dec_zero),
        .ctrl          (ctrl),
        .state         (state),
        .sync_acc      (sync_acc),
        .hold_load     (hold_load),
        .hold_run      (hold_run),
        .dec_load      (dec_load),
        .dec_run       (dec_run),
        .update_strobe (update_strobe),
        .accum_clear   (accum_clear),
        .armed         (armed)
    );

    agc_sync_downcnt #(.W(HOLD_W)) u_hold_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (holdoff),
        .dec_en   (hold_run),
        .cnt      (hold_cnt),
        .zero     (hold_zero)
    );

    agc_sync_downcnt #(.W(DEC_W)) u_dec_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dec_load),
        .load_val (decim),
        .dec_en   (dec_run),
        .cnt      (dec_cnt),
        .zero     (dec_zero)
    );

endmodule

// File: rtl/agc_sync_holdoff_chk.sv
module agc_sync_holdoff_chk #(
    parameter int HOLD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              update_strobe,
    input logic              accum_clear,
    input logic              armed,
    input logic              sync_acc,
    input logic [HOLD_W-1:0] hold_cnt,
    input logic [HOLD_W-1:0] holdoff
);

    // R9
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !update_strobe);

    // R6
    clear_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accum_clear |-> update_strobe);

    // R7
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !sleep) |=> !armed);

    // R8
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_acc |=> (hold_cnt == $past(holdoff)));

    // R10
    zero_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_acc && holdoff == '0) |=> (update_strobe || sleep || sync_acc));

endmodule

bind agc_sync_holdoff agc_sync_holdoff_chk #(.HOLD_W(HOLD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep         (sleep),
    .update_strobe (update_strobe),
    .accum_clear   (accum_clear),
    .armed         (armed),
    .sync_acc      (sync_acc),
    .hold_cnt      (hold_cnt),
    .holdoff       (holdoff)
);

// File: tb/tb_agc_sync_holdoff.sv
module tb_agc_sync_holdoff;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD_W     = 16;

    typedef struct {
        int    cyc;
        bit    clr;
        string req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [HOLD_W-1:0] wr_data = '0;
    logic              ext_sync = 1'b0;
    logic              update_strobe;
    logic              accum_clear;
    logic              armed;

    int   cyc = 0;
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 1'b0;
    exp_t q[$];

    agc_sync_holdoff #(.HOLD_W(HOLD_W), .DEC_W(8)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .ext_sync      (ext_sync),
        .update_strobe (update_strobe),
        .accum_clear   (accum_clear),
        .armed         (armed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_until(input int n);
        while (cyc < n) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [HOLD_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic push(input int c, input bit clr, input string req);
        exp_t e;
        e.cyc = c; e.clr = clr; e.req = req;
        q.push_back(e);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic doze();
        sleep = 1'b1;
        tick();
        tick();
    endtask

    // monitor: compare strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                compared++; mismatched++;
                $display("FAIL %s: actual no strobe expected strobe at cycle %0d", q[0].req, q[0].cyc);
                void'(q.pop_front());
            end
            if (update_strobe) begin
                compared++;
                if (q.size() == 0 || q[0].cyc != cyc) begin
                    mismatched++;
                    $display("FAIL R2/R3: actual strobe at cycle %0d expected none (next due %0d)",
                             cyc, (q.size() > 0) ? q[0].cyc : -1);
                end else begin
                    if (accum_clear != q[0].clr) begin
                        mismatched++;
                        $display("FAIL R6 (%s): actual accum_clear %0d expected %0d at cycle %0d",
                                 q[0].req, accum_clear, q[0].clr, cyc);
                    end
                    void'(q.pop_front());
                end
            end else if (accum_clear) begin
                compared++; mismatched++;
                $display("FAIL R6: actual accum_clear 1 expected 0 at cycle %0d", cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int c;
        int c2;
        tick(); tick();
        // R1 reset state
        chk("R1 strobe", int'(update_strobe), 0);
        chk("R1 clear", int'(accum_clear), 0);
        chk("R1 armed", int'(armed), 1);
        rst_n = 1'b1;
        tick();
        chk("R1 armed after reset", int'(armed), 1);

        // R2, R3, R9: wake with H=5, D=3, then sleep on a strobe cycle
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'd0);
        sleep = 1'b0; c = cyc;
        push(c + 6, 0, "R2"); push(c + 10, 0, "R3"); push(c + 14, 0, "R3");
        tick();
        run_until(c + 18);
        sleep = 1'b1;            // R9: strobe due now must be suppressed
        tick(); tick();

        // R8, R4, R6: sync-now during wake countdown restarts it
        wr(2'd1, 16'd10);
        wr(2'd0, 16'd4);
        sleep = 1'b0; c = cyc;
        tick();
        run_until(c + 4);
        c2 = cyc;
        push(c2 + 11, 1, "R8/R4/R6"); push(c2 + 15, 0, "R6 decim");
        wr(2'd0, 16'd12);
        run_until(c2 + 16);
        doze();

        // R5: ext_sync ignored while disabled
        wr(2'd0, 16'd0);
        sleep = 1'b0; c = cyc;
        push(c + 11, 0, "R5 ignored");
        tick();
        run_until(c + 3);
        ext_sync = 1'b1; tick(); ext_sync = 1'b0;
        run_until(c + 12);
        doze();

        // R5: ext_sync honoured when enabled
        wr(2'd0, 16'd1);
        sleep = 1'b0; c = cyc;
        tick();
        run_until(c + 3);
        c2 = cyc;
        push(c2 + 11, 0, "R5 honoured");
        ext_sync = 1'b1; tick(); ext_sync = 1'b0;
        run_until(c2 + 12);
        doze();

        // R7: one-shot arming, H=3, D=7
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd7);
        wr(2'd0, 16'd3);
        sleep = 1'b0; c = cyc;
        tick();
        c2 = cyc;
        push(c2 + 4, 0, "R7 first");
        ext_sync = 1'b1; tick(); ext_sync = 1'b0;
        chk("R7 armed drops", int'(armed), 0);
        run_until(c2 + 6);
        push(c2 + 12, 0, "R7 ignored"); push(c2 + 20, 0, "R7 ignored");
        ext_sync = 1'b1; tick(); ext_sync = 1'b0;
        run_until(c2 + 21);
        chk("R7 armed stays low", int'(armed), 0);
        doze();
        chk("R9 armed restored", int'(armed), 1);

        // R10, R11: hold-off zero, sync-now uses old one-shot setting
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'd0);
        sleep = 1'b0; c = cyc;
        push(c + 1, 0, "R10 wake");
        tick(); tick();
        c2 = cyc;
        push(c2 + 1, 0, "R10 sync"); push(c2 + 4, 0, "R3 after sync");
        wr(2'd0, 16'd10);
        chk("R11 armed kept", int'(armed), 1);
        run_until(c2 + 5);
        doze();

        // R11: address 3 writes are ignored
        wr(2'd1, 16'd2);
        wr(2'd3, 16'h00FF);
        wr(2'd0, 16'd0);
        sleep = 1'b0; c = cyc;
        push(c + 3, 0, "R11 addr3");
        tick();
        run_until(c + 4);
        doze();

        tick(); tick();
        done = 1'b1;
        chk("R2 queue drained", q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule